// File: doc/BRIEF.md
# Start-Triggered Counting Sequencer

This block is a three-phase controller with a small data register set. It waits in an idle phase until a start input is seen, then clears a 4-bit count register and a finish flag and enters a counting phase. In the counting phase the count rises by one on every clock. On the same edge a one-bit tracking flag copies bit 1 of the count as it stood before that increment.

The counting phase ends when bits 1 and 2 of the count, as they stood before the cycle's update, are both high. For a run that starts from zero the machine therefore spends seven cycles counting and reaches the finish phase holding the value 7. The finish phase sets the finish flag and always returns to idle one cycle later. The count, the tracking flag and the finish flag keep their values in idle until the next start.

The phase register uses the codes idle = 00, counting = 01 and finish = 11. The code 10 is not used, and the machine falls back to idle from it on the next edge. The asynchronous active-low reset takes effect at once, and its release is synchronised to the clock inside the block.

Top module: `asm_count_seq`

## Requirements
- R1: While reset is asserted, and after it is released, phase_o is 3'b001 (idle), count_o is 0, and e_flag_o and f_flag_o are 0.
- R2: In idle with start_i low, count_o, e_flag_o, f_flag_o and phase_o all hold their values on the next edge.
- R3: In idle with start_i high, the next edge enters the counting phase (phase_o = 3'b010) with count_o = 0 and f_flag_o = 0; e_flag_o is left unchanged.
- R4: In the counting phase, count_o increases by exactly 1 on every edge.
- R5: In the counting phase, each edge loads e_flag_o with count_o[1] as it was before that edge.
- R6: The counting phase moves to finish (phase_o = 3'b100) on an edge exactly when count_o[1] and count_o[2] were both 1 before that edge; otherwise it stays counting. A run that starts from 0 counts for 7 cycles and enters finish with count_o = 7 and e_flag_o = 1.
- R7: From finish the next edge always returns to idle, whatever start_i is, and sets f_flag_o to 1; count_o and e_flag_o are unchanged.
- R8: phase_o is one-hot: bit 0 means idle, bit 1 counting, bit 2 finish, and exactly one bit is set.
- R9: start_i has no effect outside idle: a high start_i during counting neither clears nor stalls count_o.
- R10: f_flag_o stays 1 in idle after a run until the next start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begins a run when seen in idle |
| count_o | output | 4 | Count register; bit 0 is the lowest bit |
| e_flag_o | output | 1 | Tracking flag loaded from count bit 1 while counting |
| f_flag_o | output | 1 | Finish flag, set in the finish phase |
| phase_o | output | 3 | One-hot phase: bit 0 idle, bit 1 counting, bit 2 finish |

## Verification
The bound checker watches every cycle for the idle hold, the clearing done by a start, the one-step increment, the tracking flag copying the old bit 1, the exit condition from counting, the forced return from finish with the flag set, and the one-hot phase. The bench scenarios cover what no single-cycle property can show. These are the seven-cycle length of a run from zero and its final value of 7. They also include the reset values, a start held high for a whole run (ignored while counting, then accepted again in idle), the finish flag surviving a long idle, and an asynchronous reset during a run.

// File: rtl/asm_seq_pkg.sv
package asm_seq_pkg;

  // Phase codes; 2'b10 is never used.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_COUNT  = 2'b01,
    ST_FINISH = 2'b11
  } seq_state_e;

  localparam int unsigned PHASE_N = 3;

  localparam int unsigned PH_IDLE   = 0;
  localparam int unsigned PH_COUNT  = 1;
  localparam int unsigned PH_FINISH = 2;

endpackage

// File: rtl/asm_seq_rst_sync.sv
module asm_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= 1'b0;
        else         shift_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = shift_q[STAGES-1];

endmodule

// File: rtl/asm_seq_ctrl.sv
module asm_seq_ctrl
  import asm_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               bit_lo_i,
  input  logic               bit_hi_i,
  output logic               clr_en_o,
  output logic               inc_en_o,
  output logic               fset_en_o,
  output logic [PHASE_N-1:0] phase_o
);

  seq_state_e state_q, state_d;
  logic in_idle, in_count, in_finish;

  // Next-state logic. Decisions look at register values before the update.
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   state_d = start_i ? ST_COUNT : ST_IDLE;
      ST_COUNT:  state_d = (bit_lo_i && bit_hi_i) ? ST_FINISH : ST_COUNT;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_idle   = (state_q == ST_IDLE);
  assign in_count  = (state_q == ST_COUNT);
  assign in_finish = (state_q == ST_FINISH);

  assign clr_en_o  = in_idle && start_i;
  assign inc_en_o  = in_count;
  assign fset_en_o = in_finish;

  always_comb begin
    phase_o            = '0;
    phase_o[PH_IDLE]   = in_idle;
    phase_o[PH_COUNT]  = in_count;
    phase_o[PH_FINISH] = in_finish;
  end

endmodule

// File: rtl/asm_seq_dp.sv
module asm_seq_dp #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LO_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en_i,
  input  logic             inc_en_i,
  input  logic             fset_en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             e_flag_o,
  output logic             f_flag_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             e_q, f_q;

  // Count register: clear on start, increment while counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (clr_en_i) count_q <= '0;
    else if (inc_en_i) count_q <= count_q + ONE;
  end

  // Tracking flag: takes the pre-increment bit while counting.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        e_q <= 1'b0;
    else if (inc_en_i) e_q <= count_q[LO_BIT];
  end

  // Finish flag: cleared on start, set in the finish phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         f_q <= 1'b0;
    else if (clr_en_i)  f_q <= 1'b0;
    else if (fset_en_i) f_q <= 1'b1;
  end

  assign count_o  = count_q;
  assign e_flag_o = e_q;
  assign f_flag_o = f_q;

endmodule

// File: rtl/asm_count_seq.sv
module asm_count_seq
  import asm_seq_pkg::*;
#(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned LO_BIT     = 1,
  parameter int unsigned HI_BIT     = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [CNT_W-1:0] count_o,
  output logic             e_flag_o,
  output logic             f_flag_o,
  output logic [2:0]       phase_o
);

  logic             rst_core_n;
  logic             clr_en, inc_en, fset_en;
  logic [CNT_W-1:0] count_w;

  asm_seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_core_n)
  );

  asm_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_i   (start_i),
    .bit_lo_i  (count_w[LO_BIT]),
    .bit_hi_i  (count_w[HI_BIT]),
    .clr_en_o  (clr_en),
    .inc_en_o  (inc_en),
    .fset_en_o (fset_en),
    .phase_o   (phase_o)
  );

  asm_seq_dp #(.CNT_W(CNT_W), .LO_BIT(LO_BIT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr_en_i  (clr_en),
    .inc_en_i  (inc_en),
    .fset_en_i (fset_en),
    .count_o   (count_w),
    .e_flag_o  (e_flag_o),
    .f_flag_o  (f_flag_o)
  );

  assign count_o = count_w;

endmodule

// File: rtl/asm_count_seq_chk.sv
module asm_count_seq_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LO_BIT = 1,
  parameter int unsigned HI_BIT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [CNT_W-1:0] count_o,
  input logic             e_flag_o,
  input logic             f_flag_o,
  input logic [2:0]       phase_o
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[0] && !start_i) |=> ($stable(count_o) && $stable(e_flag_o) &&
                                  $stable(f_flag_o) && phase_o == 3'b001)); // R2

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[0] && start_i) |=> (phase_o == 3'b010 && count_o == '0 &&
                                 !f_flag_o && $stable(e_flag_o))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[1] |=> (count_o == $past(count_o) + CNT_W'(1))); // R4

  AST_TRACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[1] |=> (e_flag_o == $past(count_o[LO_BIT]))); // R5

  AST_EXIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[1] && count_o[LO_BIT] && count_o[HI_BIT]) |=> (phase_o == 3'b100)); // R6

  AST_EXIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[1] && !(count_o[LO_BIT] && count_o[HI_BIT])) |=> (phase_o == 3'b010)); // R6

  AST_FINISH_RET: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o[2] |=> (phase_o == 3'b001 && f_flag_o &&
                    $stable(count_o) && $stable(e_flag_o))); // R7

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_o) == 1); // R8

endmodule

bind asm_count_seq asm_count_seq_chk #(
  .CNT_W(CNT_W), .LO_BIT(LO_BIT), .HI_BIT(HI_BIT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .start_i  (start_i),
  .count_o  (count_o),
  .e_flag_o (e_flag_o),
  .f_flag_o (f_flag_o),
  .phase_o  (phase_o)
);

// File: tb/asm_count_seq_tb_top.sv
`timescale 1ns/1ps
module asm_count_seq_tb_top;

  localparam int unsigned CLK_HALF = 4;  // 125 MHz

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] count_o;
  logic       e_flag_o;
  logic       f_flag_o;
  logic [2:0] phase_o;

  int checks = 0;
  int errors = 0;

  asm_count_seq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .count_o  (count_o),
    .e_flag_o (e_flag_o),
    .f_flag_o (f_flag_o),
    .phase_o  (phase_o)
  );

  initial clk = 1'b0;
  always #CLK_HALF clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Advance one edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check_all(input string req, input int c, input int e, input int f, input int ph);
    check(req, "count", int'(count_o), c);
    check(req, "e_flag", int'(e_flag_o), e);
    check(req, "f_flag", int'(f_flag_o), f);
    check(req, "phase", int'(phase_o), ph);
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    #1;
    check_all("R1", 0, 0, 0, 1);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check_all("R1", 0, 0, 0, 1);
  endtask

  task automatic t_idle_hold();
    for (int i = 0; i < 5; i++) begin
      tick();
      check_all("R2", 0, 0, 0, 1);
    end
  endtask

  // One run from 0; start_i is held for the whole run when hold_start is set.
  task automatic t_run(input bit hold_start, input int e_before, input int f_before);
    start_i = 1'b1;
    tick();
    check_all("R3", 0, e_before, 0, 2);
    if (!hold_start) start_i = 1'b0;
    for (int i = 1; i <= 7; i++) begin
      tick();
      check(hold_start ? "R9" : "R4", "count", int'(count_o), i);
      check("R5", "e_flag", int'(e_flag_o), ((i - 1) >> 1) & 1);
      check("R6", "phase", int'(phase_o), (i < 7) ? 2 : 4);
    end
    check("R6", "final count", int'(count_o), 7);
    start_i = hold_start ? 1'b1 : 1'b0;
    tick();
    check_all("R7", 7, 1, 1, 1);
  endtask

  task automatic t_flag_persist();
    start_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R10", "f_flag", int'(f_flag_o), 1);
      check("R2", "phase", int'(phase_o), 1);
    end
    check_all("R10", 7, 1, 1, 1);
  endtask

  task automatic t_reset_midrun();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    repeat (3) tick();
    check("R4", "count before reset", int'(count_o), 3);
    rst_n = 1'b0;
    #1;
    check_all("R1", 0, 0, 0, 1);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    check_all("R1", 0, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_run(1'b0, 0, 0);
    t_flag_persist();
    // start held high through the run: ignored while counting,
    // finish still returns to idle, then the next start is taken
    t_run(1'b1, 1, 1);
    t_run(1'b0, 1, 1);
    start_i = 1'b0;
    tick();
    check_all("R2", 7, 1, 1, 1);
    t_reset_midrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule